// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block derives the two timing strobes a UART needs from the peripheral clock. The first is a sixteen-times-oversampling strobe (`tick16`), used for sampling on the receive side. The second is a once-per-bit strobe (`tick_bit`), used by the transmitter. The divisor is the peripheral clock frequency over sixteen times the baud rate. It has a 16-bit whole part and a 6-bit part in 1/64 steps. The 6-bit part is set to the divisor's remainder times 64, rounded to the nearest integer. For example, a 50 MHz clock and 115200 baud give a whole part of 27 and a fraction of 8.

Software loads the divisor through a small write port, one register per cycle. The whole part and the fraction go into holding registers that have no effect on timing. Writing the line-control byte copies both holding registers into the working divisor, together with the byte itself. These three fields make up a 30-bit working word. The same write restarts the period counter, the fraction accumulator and the bit divider, so the new rate takes effect on a clean boundary.

The fraction is spread over successive strobe periods. A 6-bit accumulator grows by the fraction at each `tick16`. When it overflows, the next period is one clock longer than the whole part.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset all registers are zero. `tick16` and `tick_bit` stay low, and `line_cfg` reads 0, until a line-control write latches a non-zero whole part.
- R2: The write port uses `wr_sel` to pick a register: 0 is the whole part, 1 is the fraction (the low 6 bits of `wr_data`), 2 is line control, and 3 selects nothing. Writes with selector 0, 1 or 3 change neither the strobe timing nor `line_cfg`.
- R3: A write with selector 2 latches the held whole part, the held fraction and `wr_data[7:0]` as one working word. `line_cfg` shows the new byte from the next cycle on.
- R4: Call the clock cycle right after the latching edge cycle 1. With a working whole part I, the first `tick16` after a latch is high in cycle I.
- R5: Each strobe period, measured from one high `tick16` cycle to the next, lasts I or I+1 clocks. A 6-bit accumulator is cleared at the latch and grows by the fraction F at every `tick16`. The period that follows a given `tick16` is I+1 exactly when that addition overflows. The first period after a latch therefore lasts I.
- R6: Any 64 consecutive strobe periods add up to exactly 64*I + F clocks.
- R7: `tick_bit` is high together with the 16th, 32nd, 48th and later `tick16` pulses counted from the latch, and at no other time.
- R8: A working whole part of zero stops both strobes.
- R9: A latch made in a cycle where `tick16` (and possibly `tick_bit`) is high leaves that pulse in place. The new schedule then starts as in R4, and the bit count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 whole part, 1 fraction, 2 line control, 3 none) |
| wr_data | input | 16 | Write data |
| tick16 | output | 1 | Oversampling strobe, high one cycle per period |
| tick_bit | output | 1 | Bit strobe, high with every 16th `tick16` |
| line_cfg | output | 8 | Working line-control byte |

## Verification
The line-control latch and a `tick16` pulse can fall in the same cycle. In the worst case that pulse is also a `tick_bit`, because the bit divider wraps on it. The bench waits until it sees `tick_bit` high and issues the latch in that same cycle. The scoreboard expects the old pulse to appear exactly once. It then expects the first new pulse I cycles later, and the next `tick_bit` on the 16th new pulse, not on a count carried over from the old rate.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int LCR_W  = 8,
  parameter int OSR    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [INT_W-1:0] wr_data,
  output logic             tick16,
  output logic             tick_bit,
  output logic [LCR_W-1:0] line_cfg
);
  localparam int SUB_W = $clog2(OSR);
  localparam int CNT_W = INT_W + 1;

  logic [INT_W-1:0]  stg_int, work_int;
  logic [FRAC_W-1:0] stg_frac, work_frac, acc;
  logic [FRAC_W:0]   acc_sum;
  logic              extra;
  logic [CNT_W-1:0]  cnt, lim;
  logic [SUB_W-1:0]  sub;

  wire latch_wr = wr_en && (wr_sel == 2'd2);
  wire run      = |work_int;

  assign acc_sum  = {1'b0, acc} + {1'b0, work_frac};
  assign lim      = {1'b0, work_int} + CNT_W'(extra) - CNT_W'(1);
  assign tick16   = run && (cnt == lim);
  assign tick_bit = tick16 && (sub == SUB_W'(OSR - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_int  <= '0;
      stg_frac <= '0;
    end else if (wr_en) begin
      if (wr_sel == 2'd0) stg_int  <= wr_data;
      if (wr_sel == 2'd1) stg_frac <= wr_data[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_int  <= '0;
      work_frac <= '0;
      line_cfg  <= '0;
    end else if (latch_wr) begin
      work_int  <= stg_int;
      work_frac <= stg_frac;
      line_cfg  <= wr_data[LCR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || latch_wr) begin
      cnt   <= '0;
      acc   <= '0;
      extra <= 1'b0;
      sub   <= '0;
    end else if (tick16) begin
      cnt   <= '0;
      acc   <= acc_sum[FRAC_W-1:0];
      extra <= acc_sum[FRAC_W];
      sub   <= (sub == SUB_W'(OSR - 1)) ? '0 : sub + SUB_W'(1);
    end else if (run) begin
      cnt   <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int LCR_W  = 8,
  parameter int OSR    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [LCR_W-1:0]  lcr_in,
  input logic              tick16,
  input logic              tick_bit,
  input logic [LCR_W-1:0]  line_cfg,
  input logic [INT_W-1:0]  work_int,
  input logic [FRAC_W-1:0] work_frac,
  input logic [FRAC_W-1:0] acc,
  input logic [INT_W:0]    cnt,
  input logic [$clog2(OSR)-1:0] sub
);
  wire latch_wr = wr_en && (wr_sel == 2'd2);

  assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != 2'd2) |=> ($stable(line_cfg) && $stable(work_int) && $stable(work_frac)));

  assert_latch_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_wr |=> (line_cfg == $past(lcr_in)));

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_wr |=> (cnt == '0 && acc == '0 && sub == '0));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= {1'b0, work_int});

  assert_bit_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_bit |-> tick16);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (work_int == '0) |-> !tick16);

  assert_coincide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    latch_wr |=> !tick_bit);
endmodule

bind frac_baud_gen frac_baud_gen_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .LCR_W(LCR_W), .OSR(OSR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .lcr_in(wr_data[LCR_W-1:0]), .tick16(tick16), .tick_bit(tick_bit),
  .line_cfg(line_cfg), .work_int(work_int), .work_frac(work_frac),
  .acc(acc), .cnt(cnt), .sub(sub)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        tick16, tick_bit;
  logic [7:0]  line_cfg;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick16(tick16), .tick_bit(tick_bit), .line_cfg(line_cfg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int t; bit b; } exp_t;
  exp_t  sb[$];
  int    obs[$];
  int    ncount = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    stg_int = 0, stg_frac = 0;

  always @(posedge clk) ncount <= ncount + 1;

  // monitor: pops expected strobes and compares them with what the design shows
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (sb.size() > 0 && sb[0].t < ncount) begin
        checks++; fails++;
        $display("FAIL %s missed tick16 at cycle %0d: actual 0 expected 1", cur_req, sb[0].t);
        void'(sb.pop_front());
      end
      if (tick16) begin
        checks++;
        if (sb.size() > 0 && sb[0].t == ncount) begin
          if (tick_bit !== sb[0].b) begin
            fails++;
            $display("FAIL R7 tick_bit at cycle %0d: actual %0b expected %0b", ncount, tick_bit, sb[0].b);
          end
          obs.push_back(ncount);
          void'(sb.pop_front());
        end else begin
          fails++;
          $display("FAIL %s unexpected tick16 at cycle %0d: actual 1 expected 0", cur_req, ncount);
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input int d);
    wr_en = 1'b1; wr_sel = s; wr_data = 16'(d);
    wait_cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int i, input int f);
    wr(2'd0, i); stg_int = i;
    wr(2'd1, f); stg_frac = f % 64;
  endtask

  function automatic int span_for(input int i);
    return (i == 0) ? 100 : 65 * (i + 1) + 20;
  endfunction

  // driver: latches line control, pushes the expected strobe schedule
  task automatic latch_run(input int lcr, input string tag);
    int n0, t, acc, idx, c, span, wi, wf;
    wi = stg_int; wf = stg_frac; span = span_for(wi);
    cur_req = tag;
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'(lcr);
    n0 = ncount + 1;
    sb.delete(); obs.delete();
    if (wi > 0) begin
      acc = 0; t = n0 + wi - 1; idx = 0;
      while (t < n0 + span + 200) begin
        sb.push_back('{t, (idx % 16) == 15});
        c = ((acc + wf) >= 64) ? 1 : 0;
        acc = (acc + wf) % 64;
        t += wi + c; idx++;
      end
    end
    wait_cyc(1);
    wr_en = 1'b0;
    check("R3", int'(line_cfg), lcr & 8'hFF, "line_cfg after latch");
    wait_cyc(span - 1);
    if (wi > 0) begin
      check("R4", (obs.size() > 0) ? obs[0] : -1, n0 + wi - 1, "first tick16 cycle");
      check("R6", (obs.size() > 64) ? obs[64] - obs[0] : -1, 64 * wi + wf, "64-period length");
    end else begin
      check("R8", obs.size(), 0, "ticks with zero divisor");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(10);
    check("R1", int'(tick16), 0, "tick16 after reset");
    check("R1", int'(tick_bit), 0, "tick_bit after reset");
    check("R1", int'(line_cfg), 0, "line_cfg after reset");

    set_div(1, 0);   latch_run(8'h11, "R5");
    set_div(1, 63);  latch_run(8'h22, "R5");
    set_div(27, 8);  latch_run(8'h33, "R5");
    set_div(2, 63);  latch_run(8'h3C, "R5");

    // R2: staged writes and an unmapped select leave timing and line_cfg alone
    set_div(4, 17);  latch_run(8'h44, "R2");
    set_div(9, 3);
    wr(2'd3, 16'hBEEF);
    wait_cyc(10);
    check("R2", int'(line_cfg), 8'h44, "line_cfg after staged writes");
    latch_run(8'h55, "R3");

    // R9: latch in the very cycle a bit strobe is high
    set_div(3, 32);  latch_run(8'h66, "R5");
    set_div(5, 1);
    while (tick_bit !== 1'b1) wait_cyc(1);
    latch_run(8'h77, "R9");

    // R8: zero whole part halts both strobes
    set_div(0, 5);   latch_run(8'h88, "R8");
    check("R8", sb.size(), 0, "pending schedule when idle");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule